// File: doc/BRIEF.md
# System-Control Coprocessor Trap Entry Unit

This block keeps the control registers a small 32-bit RISC core needs to handle traps: a status word, a cause word, a saved return address, a fixed identity word and the fetch address itself. When the pipeline reports a fault, the unit records the fault code and the branch-delay position in the cause word. It saves the return address, pushes the interrupt-enable and kernel-mode pair in the status word one level deeper, and sends the fetch address to one of two vectors.

External interrupt sources are reduced to one pending level every cycle, and that level is kept in the cause word. An interrupt trap is raised by the unit itself when that level, the global enable and the matching mask bit are all set. A return-from-trap strobe pops the mode stack. Software may read all four registers through a small select port. It may rewrite the status word and the two software-interrupt bits of the cause word, and nothing else.

Top module: `cop0_trap_unit`

## Requirements
- R1: After reset the fetch address is 0xBFC00000, status is 0x10600000, identity is 0x00000002, and cause and the saved address are 0.
- R2: On trap entry, cause bits 31:30 take the branch-delay field, bits 6:2 take the 5-bit fault code, bits 9:8 keep their old value, bit 10 takes the current pending level and every other bit becomes 0.
- R3: On trap entry the saved address becomes the fetch address minus 4 when the branch-delay field is nonzero, and the fetch address itself when it is zero.
- R4: On trap entry the fetch address becomes 0xBFC00180 when status bit 22 is 1, and 0x80000080 when it is 0.
- R5: On trap entry status bits 5:0 become the old bits 3:0 followed by two zero bits. Status bits 31:6 are unchanged.
- R6: After every clock edge out of reset, cause bit 10 equals the OR over all sources of (source status AND source mask) sampled at that edge.
- R7: An interrupt trap fires in the same cycle (trap_fire high) when the pending level, status bit 0 and status bit 10 are all 1. It enters with fault code 0 and branch-delay field 0.
- R8: When a fault request and a qualified interrupt arrive together, the fault request is taken with its own code and delay field, and trap_irq stays 0.
- R9: A return strobe copies status bits 5:2 into bits 3:0 and leaves bits 5:4 and 31:6 unchanged.
- R10: Register select codes are 0 status, 1 cause, 2 saved address, 3 identity. A software write to cause changes only bits 9:8. Writes to the saved address and identity have no effect.
- R11: Trap entry takes priority over a return strobe and over a software write to status or cause in the same cycle. A return strobe takes priority over a software write to status.
- R12: Without a trap, pc_load replaces the fetch address with pc_next. In a trap cycle the vector wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_req | input | 1 | Pipeline requests trap entry this cycle |
| fault_code | input | 5 | Fault code written to cause bits 6:2 |
| fault_bdt | input | 2 | Branch-delay field written to cause bits 31:30 |
| ret_strobe | input | 1 | Return from trap: pop the mode stack |
| pc_load | input | 1 | Load pc_next into the fetch address |
| pc_next | input | 32 | Next fetch address from the pipeline |
| irq_status | input | NUM_IRQ | Per-source interrupt status |
| irq_mask | input | NUM_IRQ | Per-source interrupt mask |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Software write select |
| sw_wdata | input | 32 | Software write data |
| rd_sel | input | 2 | Read select |
| rd_data | output | 32 | Selected register value |
| pc_out | output | 32 | Current fetch address |
| trap_fire | output | 1 | A trap is entered at the coming edge |
| trap_irq | output | 1 | The trap this cycle is an interrupt trap |

## Verification
Trap entry can meet three other actions in the same cycle: a qualified interrupt, a return strobe, or a software write to status or cause. The bench drives each of these pairs together in one cycle. It then reads back the status and cause words, the vector and trap_irq, and expects the trap to win. Sweeps over every branch-delay value, both vector settings and all 64 low status patterns check the trap results. A sweep over enable, mask bit 10 and 4-bit status and mask patterns checks interrupt qualification and the pending level in cause.

// File: rtl/cop0_pkg.sv
package cop0_pkg;

    localparam int XLEN = 32;
    localparam int CODE_W = 5;
    localparam int BDT_W = 2;

    localparam logic [XLEN-1:0] BOOT_PC    = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] BOOT_SR    = 32'h1060_0000;
    localparam logic [XLEN-1:0] IDENT_WORD = 32'h0000_0002;
    localparam logic [XLEN-1:0] VEC_ROM    = 32'hBFC0_0180;
    localparam logic [XLEN-1:0] VEC_RAM    = 32'h8000_0080;

    localparam int SR_VEC_BIT   = 22;
    localparam int SR_IE_BIT    = 0;
    localparam int SR_HWIM_BIT  = 10;
    localparam int CA_HWIP_BIT  = 10;
    localparam int CA_CODE_LO   = 2;
    localparam int CA_BDT_LO    = 30;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_RETPC  = 2'd2,
        SEL_IDENT  = 2'd3
    } creg_sel_e;

    typedef struct packed {
        logic              fire;
        logic              is_irq;
        logic [BDT_W-1:0]  bdt;
        logic [CODE_W-1:0] code;
    } entry_t;

    typedef struct packed {
        logic pop;
        logic sr_wr;
        logic cause_wr;
    } side_t;

    // Push the two-deep mode stack: low nibble moves up two places.
    function automatic logic [XLEN-1:0] sr_push(input logic [XLEN-1:0] sr);
        logic [XLEN-1:0] r;
        r      = sr;
        r[5:0] = {sr[3:0], 2'b00};
        return r;
    endfunction

    // Pop the stack: bits 5:2 move down, bits 5:4 stay.
    function automatic logic [XLEN-1:0] sr_pop(input logic [XLEN-1:0] sr);
        logic [XLEN-1:0] r;
        r      = sr;
        r[3:0] = sr[5:2];
        return r;
    endfunction

    function automatic logic [XLEN-1:0] cause_enter(
        input logic [XLEN-1:0]   old,
        input logic [BDT_W-1:0]  bdt,
        input logic [CODE_W-1:0] code
    );
        logic [XLEN-1:0] r;
        r = '0;
        r[CA_BDT_LO +: BDT_W]   = bdt;
        r[9:8]                  = old[9:8];
        r[CA_CODE_LO +: CODE_W] = code;
        return r;
    endfunction

    function automatic logic [XLEN-1:0] retpc_enter(
        input logic [XLEN-1:0]  pc,
        input logic [BDT_W-1:0] bdt
    );
        return (bdt != '0) ? (pc - 32'd4) : pc;
    endfunction

    function automatic logic [XLEN-1:0] vector_of(input logic [XLEN-1:0] sr);
        return sr[SR_VEC_BIT] ? VEC_ROM : VEC_RAM;
    endfunction

endpackage

// File: rtl/cop0_irq_qual.sv
module cop0_irq_qual
    import cop0_pkg::*;
#(
    parameter int NUM_IRQ = 11
) (
    input  logic [NUM_IRQ-1:0] irq_status,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               sr_ie,
    input  logic               sr_hwim,
    output logic               pending,
    output logic               take
);
    logic [NUM_IRQ-1:0] hit;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        assign hit[i] = irq_status[i] & irq_mask[i];
    end

    assign pending = |hit;
    assign take    = pending & sr_ie & sr_hwim;

endmodule

// File: rtl/cop0_entry_arb.sv
module cop0_entry_arb
    import cop0_pkg::*;
(
    input  logic              rst,
    input  logic              fault_req,
    input  logic [CODE_W-1:0] fault_code,
    input  logic [BDT_W-1:0]  fault_bdt,
    input  logic              irq_take,
    input  logic              ret_strobe,
    input  logic              sw_we,
    input  logic [1:0]        sw_sel,
    output entry_t            entry,
    output side_t             side
);
    logic fault_go;
    logic irq_go;

    always_comb begin
        fault_go = fault_req & ~rst;
        irq_go   = irq_take & ~rst;

        entry.fire   = fault_go | irq_go;
        entry.is_irq = irq_go & ~fault_go;
        entry.bdt    = fault_go ? fault_bdt : '0;
        entry.code   = fault_go ? fault_code : '0;

        side.pop      = ret_strobe & ~entry.fire & ~rst;
        side.sr_wr    = sw_we & (creg_sel_e'(sw_sel) == SEL_STATUS)
                        & ~entry.fire & ~side.pop & ~rst;
        side.cause_wr = sw_we & (creg_sel_e'(sw_sel) == SEL_CAUSE)
                        & ~entry.fire & ~rst;
    end

endmodule

// File: rtl/cop0_regfile.sv
module cop0_regfile
    import cop0_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  entry_t          entry,
    input  side_t           side,
    input  logic            pending,
    input  logic [XLEN-1:0] sw_wdata,
    input  logic            pc_load,
    input  logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] sr_q,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] retpc_q,
    output logic [XLEN-1:0] pc_q
);
    logic [XLEN-1:0] sr_d, cause_d, retpc_d, pc_d;

    always_comb begin
        sr_d = sr_q;
        if (entry.fire)
            sr_d = sr_push(sr_q);
        else if (side.pop)
            sr_d = sr_pop(sr_q);
        else if (side.sr_wr)
            sr_d = sw_wdata;
    end

    always_comb begin
        cause_d = cause_q;
        if (entry.fire)
            cause_d = cause_enter(cause_q, entry.bdt, entry.code);
        else if (side.cause_wr)
            cause_d[9:8] = sw_wdata[9:8];
        cause_d[CA_HWIP_BIT] = pending;
    end

    always_comb begin
        retpc_d = entry.fire ? retpc_enter(pc_q, entry.bdt) : retpc_q;
    end

    always_comb begin
        pc_d = pc_q;
        if (entry.fire)
            pc_d = vector_of(sr_q);
        else if (pc_load)
            pc_d = pc_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= BOOT_SR;
            cause_q <= '0;
            retpc_q <= '0;
            pc_q    <= BOOT_PC;
        end else begin
            sr_q    <= sr_d;
            cause_q <= cause_d;
            retpc_q <= retpc_d;
            pc_q    <= pc_d;
        end
    end

endmodule

// File: rtl/cop0_trap_unit.sv
module cop0_trap_unit
    import cop0_pkg::*;
#(
    parameter int NUM_IRQ = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fault_req,
    input  logic [4:0]         fault_code,
    input  logic [1:0]         fault_bdt,
    input  logic               ret_strobe,
    input  logic               pc_load,
    input  logic [31:0]        pc_next,
    input  logic [NUM_IRQ-1:0] irq_status,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               sw_we,
    input  logic [1:0]         sw_sel,
    input  logic [31:0]        sw_wdata,
    input  logic [1:0]         rd_sel,
    output logic [31:0]        rd_data,
    output logic [31:0]        pc_out,
    output logic               trap_fire,
    output logic               trap_irq
);
    logic [XLEN-1:0] sr_q, cause_q, retpc_q, pc_q;
    logic            pending, irq_take;
    entry_t          entry;
    side_t           side;

    cop0_irq_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
        .irq_status (irq_status),
        .irq_mask   (irq_mask),
        .sr_ie      (sr_q[SR_IE_BIT]),
        .sr_hwim    (sr_q[SR_HWIM_BIT]),
        .pending    (pending),
        .take       (irq_take)
    );

    cop0_entry_arb u_arb (
        .rst        (rst),
        .fault_req  (fault_req),
        .fault_code (fault_code),
        .fault_bdt  (fault_bdt),
        .irq_take   (irq_take),
        .ret_strobe (ret_strobe),
        .sw_we      (sw_we),
        .sw_sel     (sw_sel),
        .entry      (entry),
        .side       (side)
    );

    cop0_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .entry    (entry),
        .side     (side),
        .pending  (pending),
        .sw_wdata (sw_wdata),
        .pc_load  (pc_load),
        .pc_next  (pc_next),
        .sr_q     (sr_q),
        .cause_q  (cause_q),
        .retpc_q  (retpc_q),
        .pc_q     (pc_q)
    );

    always_comb begin
        unique case (creg_sel_e'(rd_sel))
            SEL_STATUS: rd_data = sr_q;
            SEL_CAUSE:  rd_data = cause_q;
            SEL_RETPC:  rd_data = retpc_q;
            default:    rd_data = IDENT_WORD;
        endcase
    end

    assign pc_out    = pc_q;
    assign trap_fire = entry.fire;
    assign trap_irq  = entry.is_irq;

endmodule

// File: rtl/cop0_trap_unit_chk.sv
module cop0_trap_unit_chk #(
    parameter int NUM_IRQ = 11
) (
    input logic               clk,
    input logic               rst,
    input logic               trap_fire,
    input logic               trap_irq,
    input logic [1:0]         fault_bdt,
    input logic [31:0]        pc_out,
    input logic [31:0]        sr,
    input logic [31:0]        cause,
    input logic [31:0]        retpc,
    input logic [NUM_IRQ-1:0] irq_status,
    input logic [NUM_IRQ-1:0] irq_mask,
    input logic               sw_we,
    input logic [1:0]         sw_sel
);
    logic pend;
    assign pend = |(irq_status & irq_mask);

    AST_VECTOR_PICK: assert property (@(posedge clk) disable iff (rst) // R4
        (trap_fire) |=> pc_out == ($past(sr[22]) ? 32'hBFC0_0180 : 32'h8000_0080));

    AST_RETPC_SAVE: assert property (@(posedge clk) disable iff (rst) // R3
        (trap_fire && !trap_irq) |=>
            retpc == (($past(fault_bdt) != 2'b00) ? $past(pc_out) - 32'd4 : $past(pc_out)));

    AST_MODE_PUSH: assert property (@(posedge clk) disable iff (rst) // R5
        (trap_fire) |=> (sr[5:0] == {$past(sr[3:0]), 2'b00}) && (sr[31:6] == $past(sr[31:6])));

    AST_PEND_LEVEL: assert property (@(posedge clk) disable iff (rst) // R6
        (!rst) |=> cause[10] == $past(pend));

    AST_IRQ_QUALIFY: assert property (@(posedge clk) disable iff (rst) // R7
        (pend && sr[0] && sr[10]) |-> trap_fire);

    AST_CAUSE_READONLY: assert property (@(posedge clk) disable iff (rst) // R10
        (!trap_fire) |=> (cause[31:11] == $past(cause[31:11])) && (cause[7:0] == $past(cause[7:0])));

    AST_ENTRY_OVER_WRITE: assert property (@(posedge clk) disable iff (rst) // R11
        (trap_fire && sw_we && sw_sel == 2'd1) |=> cause[9:8] == $past(cause[9:8]));

endmodule

bind cop0_trap_unit cop0_trap_unit_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trap_fire  (trap_fire),
    .trap_irq   (trap_irq),
    .fault_bdt  (fault_bdt),
    .pc_out     (pc_out),
    .sr         (sr_q),
    .cause      (cause_q),
    .retpc      (retpc_q),
    .irq_status (irq_status),
    .irq_mask   (irq_mask),
    .sw_we      (sw_we),
    .sw_sel     (sw_sel)
);

// File: tb/cop0_trap_unit_test.sv
`timescale 1ns/1ps
module cop0_trap_unit_test;
    localparam int NI = 11;

    logic clk = 1'b0;
    logic rst;
    logic fault_req, ret_strobe, pc_load, sw_we;
    logic [4:0] fault_code;
    logic [1:0] fault_bdt, sw_sel, rd_sel;
    logic [31:0] pc_next, sw_wdata, rd_data, pc_out;
    logic [NI-1:0] irq_status, irq_mask;
    logic trap_fire, trap_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cop0_trap_unit #(.NUM_IRQ(NI)) uut (
        .clk(clk), .rst(rst), .fault_req(fault_req), .fault_code(fault_code),
        .fault_bdt(fault_bdt), .ret_strobe(ret_strobe), .pc_load(pc_load),
        .pc_next(pc_next), .irq_status(irq_status), .irq_mask(irq_mask),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .rd_sel(rd_sel),
        .rd_data(rd_data), .pc_out(pc_out), .trap_fire(trap_fire), .trap_irq(trap_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic swr(input logic [1:0] s, input logic [31:0] d);
        sw_we = 1'b1; sw_sel = s; sw_wdata = d;
        cyc();
        sw_we = 1'b0;
    endtask

    function automatic logic [31:0] push(input logic [31:0] s);
        return (s & ~32'h3F) | ((s & 32'hF) << 2);
    endfunction

    initial begin
        #(20ns * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; fault_req = 0; ret_strobe = 0; pc_load = 0; sw_we = 0;
        fault_code = 0; fault_bdt = 0; sw_sel = 0; rd_sel = 0;
        pc_next = 0; sw_wdata = 0; irq_status = 0; irq_mask = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 pc", pc_out, 32'hBFC0_0000);
        rd(2'd0, v); chk("R1 status", v, 32'h1060_0000);
        rd(2'd3, v); chk("R1 ident", v, 32'h2);
        rd(2'd1, v); chk("R1 cause", v, 32'h0);
        rd(2'd2, v); chk("R1 retpc", v, 32'h0);

        // R10 read-only fields
        swr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R10 cause write", v, 32'h300);
        swr(2'd2, 32'h1234_5678);
        rd(2'd2, v); chk("R10 retpc write ignored", v, 32'h0);
        swr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R10 ident write ignored", v, 32'h2);
        swr(2'd1, 32'h0);

        // R12 pc load
        pc_load = 1; pc_next = 32'h8004_0000; cyc(); pc_load = 0;
        chk("R12 pc load", pc_out, 32'h8004_0000);

        // R9 return pop
        swr(2'd0, 32'h1000_002D);
        ret_strobe = 1; cyc(); ret_strobe = 0;
        rd(2'd0, v); chk("R9 pop", v, 32'h1000_002B);

        // R11 return beats status write
        ret_strobe = 1; sw_we = 1; sw_sel = 0; sw_wdata = 32'h1000_0000;
        cyc(); ret_strobe = 0; sw_we = 0;
        rd(2'd0, v); chk("R11 pop over write", v, 32'h1000_002A);

        // R11 entry beats return and status write; R12 vector beats load
        fault_req = 1; fault_code = 5'd8; fault_bdt = 2'd0;
        ret_strobe = 1; sw_we = 1; sw_sel = 0; sw_wdata = 32'h0;
        pc_load = 1; pc_next = 32'h8005_0000;
        cyc();
        fault_req = 0; ret_strobe = 0; sw_we = 0; pc_load = 0;
        rd(2'd0, v); chk("R11 entry over pop and write", v, 32'h1000_0028);
        chk("R12 vector over load", pc_out, 32'h8000_0080);

        // R11 entry beats cause write; R3 delay slot
        fault_req = 1; fault_code = 5'd8; fault_bdt = 2'd2;
        sw_we = 1; sw_sel = 1; sw_wdata = 32'h300;
        cyc();
        fault_req = 0; sw_we = 0;
        rd(2'd1, v); chk("R11 entry over cause write", v, 32'h8000_0020);
        rd(2'd2, v); chk("R3 delay-slot retpc", v, 32'h8000_007C);

        // R8 fault beats interrupt
        swr(2'd0, 32'h1000_0401);
        irq_status = 11'h1; irq_mask = 11'h1;
        fault_req = 1; fault_code = 5'd4; fault_bdt = 2'd0;
        #1;
        chk("R8 fire", {31'b0, trap_fire}, 32'h1);
        chk("R8 not irq", {31'b0, trap_irq}, 32'h0);
        cyc();
        fault_req = 0;
        rd(2'd1, v); chk("R8 fault code kept", v, 32'h0000_0410);
        irq_status = 0; irq_mask = 0;
        cyc();
        rd(2'd1, v); chk("R6 level clears", v & 32'h400, 32'h0);

        // R7 top source
        swr(2'd0, 32'h1000_0401);
        irq_status = 11'h400; irq_mask = 11'h400;
        #1;
        chk("R7 top source fires", {30'b0, trap_irq, trap_fire}, 32'h3);
        cyc();
        irq_status = 0; irq_mask = 0;
        chk("R7 top source vector", pc_out, 32'h8000_0080);

        // R2 R3 R4 R5 sweep
        for (int bev = 0; bev < 2; bev++) begin
            for (int lo = 0; lo < 64; lo++) begin
                for (int bdt = 0; bdt < 4; bdt++) begin
                    logic [31:0] srv, cw, pcv, ecause;
                    logic [4:0] code;
                    srv  = 32'h1000_0000 | (32'(bev) << 22) | 32'(lo);
                    cw   = (32'(lo) & 32'h3) << 8;
                    pcv  = 32'h8001_0000 + 32'(lo) * 16 + 32'(bdt) * 4 + 32'(bev) * 1024;
                    code = 5'((lo + bdt * 7) & 31);
                    swr(2'd0, srv);
                    swr(2'd1, cw);
                    pc_load = 1; pc_next = pcv; cyc(); pc_load = 0;
                    fault_req = 1; fault_code = code; fault_bdt = 2'(bdt);
                    cyc();
                    fault_req = 0;
                    ecause = (32'(bdt) << 30) | cw | (32'(code) << 2);
                    chk("R4 vector", pc_out, bev != 0 ? 32'hBFC0_0180 : 32'h8000_0080);
                    rd(2'd1, v); chk("R2 cause", v, ecause);
                    rd(2'd0, v); chk("R5 status push", v, push(srv));
                    rd(2'd2, v); chk("R3 retpc", v, bdt != 0 ? pcv - 32'd4 : pcv);
                end
            end
        end

        // R6 R7 sweep
        for (int ie = 0; ie < 2; ie++) begin
            for (int im = 0; im < 2; im++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int m = 0; m < 16; m++) begin
                        logic pend, take;
                        pend = (s & m) != 0;
                        take = pend && ie != 0 && im != 0;
                        irq_status = 0; irq_mask = 0;
                        pc_load = 1; pc_next = 32'h8002_0000;
                        swr(2'd0, 32'h1000_0014 | (32'(im) << 10) | 32'(ie));
                        pc_load = 0;
                        irq_status = NI'(s); irq_mask = NI'(m);
                        #1;
                        chk("R7 fire", {30'b0, trap_irq, trap_fire}, take ? 32'h3 : 32'h0);
                        cyc();
                        chk("R7 pc", pc_out, take ? 32'h8000_0080 : 32'h8002_0000);
                        rd(2'd1, v);
                        chk("R6 pending bit", v & 32'h400, pend ? 32'h400 : 32'h0);
                        if (take)
                            chk("R7 code and delay zero", v & 32'hC000_007C, 32'h0);
                        irq_status = 0; irq_mask = 0;
                    end
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule